// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block is a synchronous state machine that holds the chip's present power mode. There are five modes: full run, halt (the normal stop), low-power run, low-power wait and low-power halt. Each clock it looks at a set of control inputs and decides whether to move to another mode:

- a two-bit run-mode selector;
- a three-bit stop-mode selector;
- a wake-to-full bit;
- a permission bit that allows the low-power modes;
- a one-cycle sleep request from the processor, with its deep-sleep flag;
- a one-cycle interrupt pulse.

Clock scaling and flash-rate limiting belong to other logic. They reach this block only through one qualifier input, which says the clocks are already slow enough for low-power run.

The block drives the encoded mode and a flag that records how low-power halt was entered. The flag matters when an interrupt wakes the chip with wake-to-full clear. If low-power halt was entered from low-power run, the chip goes back to low-power run. If it was entered straight from full run, the chip goes to full run. An interrupt with wake-to-full set always returns to full run.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: An active-low reset puts the machine in full run and clears the entry flag, at any time and from any mode. The mode encoding is: full run = 000, halt = 001, low-power run = 010, low-power wait = 011, low-power halt = 100.
- R2: In full run, a sleep request with deep-sleep set, run selector 00 and stop selector 000 moves to halt. In halt, any interrupt moves back to full run.
- R3: In full run, run selector 10 moves to low-power run only while both the permission bit and the clocks-slow qualifier are 1. If either is 0, the machine stays in full run.
- R4: In low-power run, either of these returns to full run: run selector 00, or an interrupt with wake-to-full set.
- R5: In low-power run, a sleep request with deep-sleep clear moves to low-power wait. In low-power wait, an interrupt moves to low-power run if wake-to-full is 0 and to full run if it is 1.
- R6: In low-power run, a sleep request with deep-sleep set and stop selector 000 or 010 moves to low-power halt, and sets the entry flag to 0.
- R7: In full run, a sleep request with deep-sleep set, the permission bit 1 and stop selector 010 moves directly to low-power halt, and sets the entry flag to 1. The flag holds its value until the next entry into low-power halt or until reset.
- R8: In low-power halt, an interrupt moves to low-power run only when wake-to-full is 0 and the entry flag is 0. Otherwise it moves to full run.
- R9: Any sleep request or field combination not named in R2 to R8 leaves the mode unchanged. Examples: a sleep request in halt or in low-power wait, a deep sleep in full run with stop selector 001, an interrupt with wake-to-full 0 in low-power run, and a direct halt request with the permission bit 0.
- R10: When an interrupt and a sleep request arrive in the same cycle, the interrupt is acted on and the sleep request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_sel | input | 2 | Run-mode selector (00 full, 10 low-power) |
| stop_sel | input | 3 | Stop-mode selector (000 normal, 010 low-power) |
| wake_to_full | input | 1 | Interrupt wakes from low-power modes to full run |
| lp_permit | input | 1 | Permission bit for low-power modes |
| clk_slow_ok | input | 1 | Clocks are slow enough for low-power run |
| sleep_req | input | 1 | One-cycle sleep request from the processor |
| deep_req | input | 1 | Processor deep-sleep flag |
| irq | input | 1 | One-cycle interrupt pulse |
| mode_o | output | 3 | Present power mode, encoded as in R1 |
| lhalt_from_run | output | 1 | Low-power halt was entered directly from full run |

## Verification
The bench builds the block with its default parameters: a two-bit run selector and a three-bit stop selector, using codes 00/10 and 000/010. With these values every selector code named in the requirements can be driven directly. The bench also drives the neighbouring unlisted codes, such as stop selector 001, to show they are ignored. Each scenario enters low-power halt by both routes, so both settings of the entry flag meet an interrupt with wake-to-full clear. Interrupts and sleep requests are also driven in the same cycle to check priority.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_RUN   = 3'd0,
        MD_HALT  = 3'd1,
        MD_LRUN  = 3'd2,
        MD_LWAIT = 3'd3,
        MD_LHALT = 3'd4
    } pm_mode_e;

    typedef struct packed {
        pm_mode_e mode;
        logic     from_run;
    } pm_state_t;
endpackage

// File: rtl/pmc_trig_dec.sv
module pmc_trig_dec #(
    parameter int               RUN_W     = 2,
    parameter int               STOP_W    = 3,
    parameter logic [RUN_W-1:0] RUN_FULL  = 2'b00,
    parameter logic [RUN_W-1:0] RUN_LOW   = 2'b10,
    parameter logic [STOP_W-1:0] STOP_NORM = 3'b000,
    parameter logic [STOP_W-1:0] STOP_LOW  = 3'b010
) (
    input  logic [RUN_W-1:0]  run_sel,
    input  logic [STOP_W-1:0] stop_sel,
    output logic              run_full,
    output logic              run_low,
    output logic              stop_norm,
    output logic              stop_low
);
    always_comb begin
        run_full  = (run_sel == RUN_FULL);
        run_low   = (run_sel == RUN_LOW);
        stop_norm = (stop_sel == STOP_NORM);
        stop_low  = (stop_sel == STOP_LOW);
    end
endmodule

// File: rtl/pmc_wake_sel.sv
module pmc_wake_sel
    import pmc_pkg::*;
(
    input  pm_mode_e cur_mode,
    input  logic     from_run,
    input  logic     wake_to_full,
    output pm_mode_e wake_mode
);
    always_comb begin
        case (cur_mode)
            MD_LWAIT: wake_mode = wake_to_full ? MD_RUN : MD_LRUN;
            MD_LHALT: wake_mode = (wake_to_full || from_run) ? MD_RUN : MD_LRUN;
            default:  wake_mode = MD_RUN;
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int RUN_W  = 2,
    parameter int STOP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RUN_W-1:0]  run_sel,
    input  logic [STOP_W-1:0] stop_sel,
    input  logic              wake_to_full,
    input  logic              lp_permit,
    input  logic              clk_slow_ok,
    input  logic              sleep_req,
    input  logic              deep_req,
    input  logic              irq,
    output logic [MODE_W-1:0] mode_o,
    output logic              lhalt_from_run
);
    localparam logic [RUN_W-1:0]  RUN_FULL  = RUN_W'(0);
    localparam logic [RUN_W-1:0]  RUN_LOW   = RUN_W'(2);
    localparam logic [STOP_W-1:0] STOP_NORM = STOP_W'(0);
    localparam logic [STOP_W-1:0] STOP_LOW  = STOP_W'(2);

    pm_state_t st_d, st_q;
    logic      run_full, run_low, stop_norm, stop_low;
    pm_mode_e  wake_mode;
    logic      deep_sleep, light_sleep;

    pmc_trig_dec #(
        .RUN_W(RUN_W), .STOP_W(STOP_W),
        .RUN_FULL(RUN_FULL), .RUN_LOW(RUN_LOW),
        .STOP_NORM(STOP_NORM), .STOP_LOW(STOP_LOW)
    ) u_dec (
        .run_sel(run_sel), .stop_sel(stop_sel),
        .run_full(run_full), .run_low(run_low),
        .stop_norm(stop_norm), .stop_low(stop_low)
    );

    pmc_wake_sel u_wake (
        .cur_mode(st_q.mode), .from_run(st_q.from_run),
        .wake_to_full(wake_to_full), .wake_mode(wake_mode)
    );

    // An interrupt in the same cycle suppresses the sleep request
    assign deep_sleep  = sleep_req && deep_req && !irq;
    assign light_sleep = sleep_req && !deep_req && !irq;

    always_comb begin
        st_d = st_q;
        case (st_q.mode)
            MD_RUN: begin
                if (deep_sleep && run_full && stop_norm) begin
                    st_d.mode = MD_HALT;
                end else if (deep_sleep && lp_permit && stop_low) begin
                    st_d.mode     = MD_LHALT;
                    st_d.from_run = 1'b1;
                end else if (!sleep_req && !irq && run_low && lp_permit && clk_slow_ok) begin
                    st_d.mode = MD_LRUN;
                end
            end
            MD_HALT: begin
                if (irq) st_d.mode = MD_RUN;
            end
            MD_LRUN: begin
                if (irq && wake_to_full) begin
                    st_d.mode = MD_RUN;
                end else if (run_full) begin
                    st_d.mode = MD_RUN;
                end else if (light_sleep) begin
                    st_d.mode = MD_LWAIT;
                end else if (deep_sleep && (stop_norm || stop_low)) begin
                    st_d.mode     = MD_LHALT;
                    st_d.from_run = 1'b0;
                end
            end
            MD_LWAIT, MD_LHALT: begin
                if (irq) st_d.mode = wake_mode;
            end
            default: st_d.mode = MD_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MD_RUN, from_run: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o         = st_q.mode;
    assign lhalt_from_run = st_q.from_run;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk
    import pmc_pkg::*;
#(
    parameter int RUN_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RUN_W-1:0]  run_sel,
    input logic              wake_to_full,
    input logic              lp_permit,
    input logic              clk_slow_ok,
    input logic              sleep_req,
    input logic              irq,
    input logic [MODE_W-1:0] mode_o,
    input logic              lhalt_from_run
);
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o <= 3'd4); // R1
    AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1 && irq) |=> mode_o == 3'd0); // R2
    AST_LRUN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && !(lp_permit && clk_slow_ok)) |=> mode_o != 3'd2); // R3
    AST_LRUN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2 && irq && wake_to_full) |=> mode_o == 3'd0); // R4
    AST_LWAIT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3 && irq && !wake_to_full) |=> mode_o == 3'd2); // R5
    AST_LHALT_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4 && irq && lhalt_from_run) |=> mode_o == 3'd0); // R8
    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4) |=> (mode_o == 3'd4 || $stable(lhalt_from_run))); // R7
    AST_IRQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && irq && sleep_req) |=> mode_o == 3'd0); // R10
endmodule

bind pwr_mode_ctrl pmc_chk #(.RUN_W(RUN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_sel(run_sel), .wake_to_full(wake_to_full),
    .lp_permit(lp_permit), .clk_slow_ok(clk_slow_ok), .sleep_req(sleep_req),
    .irq(irq), .mode_o(mode_o), .lhalt_from_run(lhalt_from_run)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] run_sel = 2'b00;
    logic [2:0] stop_sel = 3'b000;
    logic       wake_to_full = 1'b0;
    logic       lp_permit = 1'b0;
    logic       clk_slow_ok = 1'b0;
    logic       sleep_req = 1'b0;
    logic       deep_req = 1'b0;
    logic       irq = 1'b0;
    logic [2:0] mode_o;
    logic       lhalt_from_run;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [2:0] M_RUN = 3'd0, M_HALT = 3'd1, M_LRUN = 3'd2,
                           M_LWAIT = 3'd3, M_LHALT = 3'd4;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .run_sel(run_sel), .stop_sel(stop_sel),
        .wake_to_full(wake_to_full), .lp_permit(lp_permit),
        .clk_slow_ok(clk_slow_ok), .sleep_req(sleep_req), .deep_req(deep_req),
        .irq(irq), .mode_o(mode_o), .lhalt_from_run(lhalt_from_run)
    );

    task automatic chk(input string req, input logic [2:0] exp_m, input logic exp_f);
        n_chk++;
        if (mode_o !== exp_m || lhalt_from_run !== exp_f) begin
            n_bad++;
            $display("FAIL %s: mode=%0d flag=%0d expected mode=%0d flag=%0d",
                     req, mode_o, lhalt_from_run, exp_m, exp_f);
        end
    endtask

    // Drive pulses for one clock edge, then return at the following negedge
    task automatic cyc(input logic sl, input logic dp, input logic iq);
        sleep_req = sl; deep_req = dp; irq = iq;
        @(posedge clk);
        @(negedge clk);
        sleep_req = 1'b0; deep_req = 1'b0; irq = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_sel = 2'b00; stop_sel = 3'b000; wake_to_full = 1'b0;
        lp_permit = 1'b0; clk_slow_ok = 1'b0;
    endtask

    task automatic enter_lrun();
        run_sel = 2'b10; lp_permit = 1'b1; clk_slow_ok = 1'b1;
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset state", M_RUN, 1'b0);
        rst_n = 1'b1;
        enter_lrun();
        chk("R1 prep low-power run", M_LRUN, 1'b0);
        rst_n = 1'b0;
        #1;
        chk("R1 reset from low-power run", M_RUN, 1'b0);
        do_reset();
    endtask

    task automatic t_halt();
        cyc(1'b1, 1'b1, 1'b0);
        chk("R2 enter halt", M_HALT, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        chk("R9 sleep in halt ignored", M_HALT, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R2 halt wake", M_RUN, 1'b0);
        stop_sel = 3'b001;
        cyc(1'b1, 1'b1, 1'b0);
        chk("R9 stop code 001 ignored", M_RUN, 1'b0);
        stop_sel = 3'b000;
    endtask

    task automatic t_lrun();
        run_sel = 2'b10; lp_permit = 1'b1; clk_slow_ok = 1'b0;
        cyc(1'b0, 1'b0, 1'b0);
        chk("R3 gated by slow clock", M_RUN, 1'b0);
        lp_permit = 1'b0; clk_slow_ok = 1'b1;
        cyc(1'b0, 1'b0, 1'b0);
        chk("R3 gated by permission", M_RUN, 1'b0);
        enter_lrun();
        chk("R3 enter low-power run", M_LRUN, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R9 irq wake0 keeps low-power run", M_LRUN, 1'b0);
        run_sel = 2'b00;
        cyc(1'b0, 1'b0, 1'b0);
        chk("R4 selector 00 exits", M_RUN, 1'b0);
        enter_lrun();
        wake_to_full = 1'b1;
        cyc(1'b0, 1'b0, 1'b1);
        chk("R4 irq wake1 exits", M_RUN, 1'b0);
        run_sel = 2'b00; wake_to_full = 1'b0;
    endtask

    task automatic t_lwait();
        enter_lrun();
        cyc(1'b1, 1'b0, 1'b0);
        chk("R5 enter low-power wait", M_LWAIT, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        chk("R9 sleep in wait ignored", M_LWAIT, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R5 wait wake0 to low-power run", M_LRUN, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        wake_to_full = 1'b1;
        cyc(1'b0, 1'b0, 1'b1);
        chk("R5 wait wake1 to full run", M_RUN, 1'b0);
        run_sel = 2'b00; wake_to_full = 1'b0;
    endtask

    task automatic t_lhalt_from_lrun();
        enter_lrun();
        stop_sel = 3'b001;
        cyc(1'b1, 1'b1, 1'b0);
        chk("R9 stop 001 in low-power run ignored", M_LRUN, 1'b0);
        stop_sel = 3'b010;
        cyc(1'b1, 1'b1, 1'b0);
        chk("R6 enter low-power halt via 010", M_LHALT, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R8 wake0 back to low-power run", M_LRUN, 1'b0);
        stop_sel = 3'b000;
        cyc(1'b1, 1'b1, 1'b0);
        chk("R6 enter low-power halt via 000", M_LHALT, 1'b0);
        wake_to_full = 1'b1;
        cyc(1'b0, 1'b0, 1'b1);
        chk("R8 wake1 to full run", M_RUN, 1'b0);
        run_sel = 2'b00; wake_to_full = 1'b0;
    endtask

    task automatic t_lhalt_direct();
        run_sel = 2'b00; stop_sel = 3'b010; lp_permit = 1'b0;
        cyc(1'b1, 1'b1, 1'b0);
        chk("R9 direct halt without permission", M_RUN, 1'b0);
        lp_permit = 1'b1;
        cyc(1'b1, 1'b1, 1'b0);
        chk("R7 direct entry sets flag", M_LHALT, 1'b1);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R8 direct entry wake0 to full run", M_RUN, 1'b1);
        stop_sel = 3'b000;
    endtask

    task automatic t_prio();
        run_sel = 2'b00; stop_sel = 3'b000;
        cyc(1'b1, 1'b1, 1'b1);
        chk("R10 irq beats deep sleep in full run", M_RUN, 1'b1);
        enter_lrun();
        cyc(1'b1, 1'b0, 1'b1);
        chk("R10 irq beats light sleep in low-power run", M_LRUN, 1'b1);
        run_sel = 2'b00;
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: mode=%0d expected run to complete", mode_o);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_halt();
        t_lrun();
        t_lwait();
        t_lhalt_from_lrun();
        t_lhalt_direct();
        t_prio();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule